// File: doc/BRIEF.md
# Interleaved Command / Parallel-Serializer Link Master

This block is a serial-link master that carries two kinds of traffic over one clocked link (SCK, MOSI, MISO). Command frames are written by the host as entries into a small transmit queue. Serializer frames carry a parallel input word that the block samples on every clock, so the far end always sees a recent copy of those pins. Between frames the block decides which source goes next. A queued command always wins. When the queue is empty, serializer traffic runs again, either back to back or only while a trigger input is high.

Each frame type has its own active-low select line and takes its length and clock rate from one of two attribute sets. A command entry picks its attribute set itself. Serializer frames use a set chosen by a static input. Bits returned by the slave are routed by frame type. After a serializer frame they update a parallel output register. After a command frame they are pushed into a receive queue. The word most recently sent in a serializer frame is also kept visible on a port.

Top module: `ism_link_master`

## Requirements
- R1: `par_in` is registered on every clock. A serializer frame sends the registered value from the cycle in which the frame starts. Changes to `par_in` after that point do not alter the frame in progress.
- R2: If the transmit queue is non-empty while the link is idle and enabled, the next frame is a command frame, even if a serializer frame is also permitted.
- R3: A frame in progress always completes with its full bit count. A command that arrives mid-frame waits for the frame boundary and never changes the active select.
- R4: A serializer frame starts only when three conditions hold: the link is idle, the transmit queue is empty, and either `trig_en` is 0 (continuous frames) or `trig_in` is 1. Once the queue drains, serializer frames resume.
- R5: `cs_ser_n` is low for exactly the duration of a serializer frame and `cs_cmd_n` is low for exactly the duration of a command frame. The two are never low together. SCK is low whenever both selects are high.
- R6: A transmit entry uses bits [15:0] as frame data and bit 16 as the attribute-set selector (0 selects set 0, 1 selects set 1). All other bits are ignored. A frame of N bits sends data bits [N-1:0] on MOSI, most significant bit first.
- R7: The N bits received during a serializer frame replace `par_out`, right-aligned and zero-extended, with the first received bit as the most significant bit. The bits received during a command frame are pushed into the receive queue in the same format. A push into a full receive queue is dropped.
- R8: Each SCK low half and each SCK high half lasts (div+1) clock cycles, where div comes from the frame's attribute set. MISO is sampled on the rising edge of SCK.
- R9: The frame length N is the attribute set's size field clamped to the range 4..16. The serializer frames use the set selected by `ser_attr_sel`.
- R10: New frames start only while `master_en` is 1 and `mode_cfg` equals 2'b10. With any other setting, queued entries wait and no select is asserted.
- R11: At the end of each serializer frame, `ser_last` is updated to the N-bit word just sent, zero-extended.
- R12: The transmit queue holds TX_DEPTH entries. `tx_full` rises when it is full, and a write while it is full is ignored. `rx_empty` shows when the receive queue has no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | 2 | Link mode; 2'b10 enables interleaved operation |
| master_en | input | 1 | Master operation enable |
| cfg_size0 | input | 5 | Attribute set 0 frame length (clamped 4..16) |
| cfg_div0 | input | 4 | Attribute set 0 SCK half-period minus one |
| cfg_size1 | input | 5 | Attribute set 1 frame length (clamped 4..16) |
| cfg_div1 | input | 4 | Attribute set 1 SCK half-period minus one |
| ser_attr_sel | input | 1 | Attribute set used by serializer frames |
| trig_en | input | 1 | 1: serializer frames wait for trig_in; 0: continuous |
| trig_in | input | 1 | Serializer frame trigger |
| tx_wr_en | input | 1 | Transmit queue write strobe |
| tx_wr_data | input | 32 | Transmit entry (bit 16 set select, [15:0] data) |
| tx_full | output | 1 | Transmit queue full |
| rx_rd_en | input | 1 | Receive queue pop strobe |
| rx_rd_data | output | 16 | Receive queue head word |
| rx_empty | output | 1 | Receive queue empty |
| par_in | input | 16 | Parallel input word to be serialized |
| par_out | output | 16 | Data returned in the last serializer frame |
| ser_last | output | 16 | Word sent in the last serializer frame |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_cmd_n | output | 1 | Command frame select, active low |
| cs_ser_n | output | 1 | Serializer frame select, active low |

## Verification
Several properties are checked on every cycle by the assertions: the two selects are mutually exclusive, SCK stays low between frames, an active frame keeps its select until its own last bit, and a pending entry on an idle enabled link is followed by a command select. The assertions also check that a serializer select only follows an empty queue and that a disabled link starts nothing. Other behaviour can only be shown by the bench scenarios, which compare against a slave model. These cover bit order and length clamping over a sweep of sizes and dividers, the half-period timing, and the routing of returned data to `par_out` or the receive queue. They also cover `ser_last`, trigger gating, the drop on a full receive queue, and the ignored write on a full transmit queue.

// File: rtl/ism_pkg.sv
package ism_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } shift_st_e;

   typedef enum logic {
      SRC_SER = 1'b0,
      SRC_CMD = 1'b1
   } src_e;

   localparam logic [1:0] MODE_COMBINED = 2'b10;
   localparam int         CMD_SEL_BIT   = 16;
   localparam int         MIN_FRAME     = 4;
   localparam int         ATTR_SETS     = 2;

endpackage

// File: rtl/ism_fifo.sv
module ism_fifo #(
   parameter int W     = 17,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic         full,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr_q, rd_ptr_q, wr_nx, rd_nx;
   logic [CW-1:0] count_q;
   logic          do_wr, do_rd;

   assign do_wr = wr_en && !full;
   assign do_rd = rd_en && !empty;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_nx = wr_ptr_q + AW'(1);
         assign rd_nx = rd_ptr_q + AW'(1);
      end else begin : g_wrap
         assign wr_nx = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + AW'(1);
         assign rd_nx = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (do_wr) wr_ptr_q <= wr_nx;
         if (do_rd) rd_ptr_q <= rd_nx;
         case ({do_wr, do_rd})
            2'b10:   count_q <= count_q + CW'(1);
            2'b01:   count_q <= count_q - CW'(1);
            default: count_q <= count_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr_q] <= wr_data;
   end

   assign rd_data = mem[rd_ptr_q];
   assign full    = (count_q == CW'(DEPTH));
   assign empty   = (count_q == '0);

endmodule

// File: rtl/ism_arbiter.sv
module ism_arbiter (
   input  logic link_active,
   input  logic link_idle,
   input  logic cmd_pending,
   input  logic trig_en,
   input  logic trig_in,
   output logic start_cmd,
   output logic start_ser
);
   logic may_start;
   logic ser_allowed;

   assign may_start   = link_active && link_idle;
   assign ser_allowed = !trig_en || trig_in;
   assign start_cmd   = may_start && cmd_pending;
   assign start_ser   = may_start && !cmd_pending && ser_allowed;

endmodule

// File: rtl/ism_shifter.sv
module ism_shifter
   import ism_pkg::*;
#(
   parameter int FRAME_MAX = 16,
   parameter int SZ_W      = 5,
   parameter int DIV_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  src_e                 start_src,
   input  logic [FRAME_MAX-1:0] word,
   input  logic [SZ_W-1:0]      size,
   input  logic [DIV_W-1:0]     div,
   input  logic                 miso,
   output logic                 sck,
   output logic                 mosi,
   output logic                 busy,
   output src_e                 cur_src,
   output logic                 done,
   output logic [FRAME_MAX-1:0] rx_word,
   output logic [FRAME_MAX-1:0] tx_word
);
   shift_st_e            state_q;
   src_e                 src_q;
   logic [DIV_W-1:0]     div_cnt_q, div_q;
   logic [SZ_W-1:0]      bit_cnt_q, size_q;
   logic [FRAME_MAX-1:0] tx_sh_q, rx_sh_q, word_q, frame_mask;
   logic                 half_end, last_bit;

   assign frame_mask = {FRAME_MAX{1'b1}} >> (FRAME_MAX - int'(size));
   assign half_end   = (div_cnt_q == div_q);
   assign last_bit   = (bit_cnt_q == size_q - SZ_W'(1));
   assign done       = (state_q == ST_HIGH) && half_end && last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         src_q     <= SRC_SER;
         div_cnt_q <= '0;
         div_q     <= '0;
         bit_cnt_q <= '0;
         size_q    <= SZ_W'(MIN_FRAME);
         tx_sh_q   <= '0;
         rx_sh_q   <= '0;
         word_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q   <= ST_LOW;
                  src_q     <= start_src;
                  size_q    <= size;
                  div_q     <= div;
                  div_cnt_q <= '0;
                  bit_cnt_q <= '0;
                  tx_sh_q   <= word << (FRAME_MAX - int'(size));
                  word_q    <= word & frame_mask;
                  rx_sh_q   <= '0;
               end
            end
            ST_LOW: begin
               if (half_end) begin
                  div_cnt_q <= '0;
                  state_q   <= ST_HIGH;
                  rx_sh_q   <= {rx_sh_q[FRAME_MAX-2:0], miso};
               end else begin
                  div_cnt_q <= div_cnt_q + DIV_W'(1);
               end
            end
            ST_HIGH: begin
               if (half_end) begin
                  div_cnt_q <= '0;
                  if (last_bit) begin
                     state_q <= ST_IDLE;
                  end else begin
                     bit_cnt_q <= bit_cnt_q + SZ_W'(1);
                     tx_sh_q   <= {tx_sh_q[FRAME_MAX-2:0], 1'b0};
                     state_q   <= ST_LOW;
                  end
               end else begin
                  div_cnt_q <= div_cnt_q + DIV_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sck     = (state_q == ST_HIGH);
   assign busy    = (state_q != ST_IDLE);
   assign mosi    = busy && tx_sh_q[FRAME_MAX-1];
   assign cur_src = src_q;
   assign rx_word = rx_sh_q;
   assign tx_word = word_q;

endmodule

// File: rtl/ism_link_master.sv
module ism_link_master
   import ism_pkg::*;
#(
   parameter  int FRAME_MAX = 16,
   parameter  int DIV_W     = 4,
   parameter  int TX_DEPTH  = 4,
   parameter  int RX_DEPTH  = 4,
   localparam int SZ_W      = $clog2(FRAME_MAX + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           mode_cfg,
   input  logic                 master_en,
   input  logic [SZ_W-1:0]      cfg_size0,
   input  logic [DIV_W-1:0]     cfg_div0,
   input  logic [SZ_W-1:0]      cfg_size1,
   input  logic [DIV_W-1:0]     cfg_div1,
   input  logic                 ser_attr_sel,
   input  logic                 trig_en,
   input  logic                 trig_in,
   input  logic                 tx_wr_en,
   input  logic [31:0]          tx_wr_data,
   output logic                 tx_full,
   input  logic                 rx_rd_en,
   output logic [FRAME_MAX-1:0] rx_rd_data,
   output logic                 rx_empty,
   input  logic [FRAME_MAX-1:0] par_in,
   output logic [FRAME_MAX-1:0] par_out,
   output logic [FRAME_MAX-1:0] ser_last,
   output logic                 sck,
   output logic                 mosi,
   input  logic                 miso,
   output logic                 cs_cmd_n,
   output logic                 cs_ser_n
);
   localparam int TXW = FRAME_MAX + 1;

   generate
      if (FRAME_MAX < MIN_FRAME || FRAME_MAX > CMD_SEL_BIT) begin : g_bad_frame
         $error("FRAME_MAX must lie in 4..16");
      end
      if (TX_DEPTH < 2 || RX_DEPTH < 2) begin : g_bad_depth
         $error("queue depths must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   logic                 link_active;
   logic [FRAME_MAX-1:0] par_q;
   logic [TXW-1:0]       tx_entry, tx_head;
   logic                 tx_empty;
   logic                 start_cmd, start_ser, shift_start;
   logic                 shift_busy, shift_done;
   src_e                 shift_src;
   logic [FRAME_MAX-1:0] shift_rx, shift_tx, shift_word;
   logic                 attr_sel;
   logic                 rx_full, rx_push;
   logic                 unused_entry;

   logic [SZ_W-1:0]  raw_size [ATTR_SETS];
   logic [SZ_W-1:0]  eff_size [ATTR_SETS];
   logic [DIV_W-1:0] set_div  [ATTR_SETS];

   assign link_active  = master_en && (mode_cfg == MODE_COMBINED);
   assign unused_entry = ^tx_wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) par_q <= '0;
      else        par_q <= par_in;
   end

   assign raw_size[0] = cfg_size0;
   assign raw_size[1] = cfg_size1;
   assign set_div[0]  = cfg_div0;
   assign set_div[1]  = cfg_div1;

   for (genvar g = 0; g < ATTR_SETS; g++) begin : g_attr
      assign eff_size[g] = (raw_size[g] < SZ_W'(MIN_FRAME)) ? SZ_W'(MIN_FRAME) :
                           (raw_size[g] > SZ_W'(FRAME_MAX)) ? SZ_W'(FRAME_MAX) :
                           raw_size[g];
   end

   assign tx_entry = {tx_wr_data[CMD_SEL_BIT], tx_wr_data[FRAME_MAX-1:0]};

   ism_fifo #(.W(TXW), .DEPTH(TX_DEPTH)) u_txq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tx_wr_en),
      .wr_data (tx_entry),
      .full    (tx_full),
      .rd_en   (start_cmd),
      .rd_data (tx_head),
      .empty   (tx_empty)
   );

   ism_arbiter u_arb (
      .link_active (link_active),
      .link_idle   (!shift_busy),
      .cmd_pending (!tx_empty),
      .trig_en     (trig_en),
      .trig_in     (trig_in),
      .start_cmd   (start_cmd),
      .start_ser   (start_ser)
   );

   assign shift_start = start_cmd || start_ser;
   assign attr_sel    = start_cmd ? tx_head[FRAME_MAX] : ser_attr_sel;
   assign shift_word  = start_cmd ? tx_head[FRAME_MAX-1:0] : par_q;

   ism_shifter #(.FRAME_MAX(FRAME_MAX), .SZ_W(SZ_W), .DIV_W(DIV_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (shift_start),
      .start_src (start_cmd ? SRC_CMD : SRC_SER),
      .word      (shift_word),
      .size      (eff_size[attr_sel]),
      .div       (set_div[attr_sel]),
      .miso      (miso),
      .sck       (sck),
      .mosi      (mosi),
      .busy      (shift_busy),
      .cur_src   (shift_src),
      .done      (shift_done),
      .rx_word   (shift_rx),
      .tx_word   (shift_tx)
   );

   assign rx_push = shift_done && (shift_src == SRC_CMD) && !rx_full;

   ism_fifo #(.W(FRAME_MAX), .DEPTH(RX_DEPTH)) u_rxq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rx_push),
      .wr_data (shift_rx),
      .full    (rx_full),
      .rd_en   (rx_rd_en),
      .rd_data (rx_rd_data),
      .empty   (rx_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_out  <= '0;
         ser_last <= '0;
      end else if (shift_done && shift_src == SRC_SER) begin
         par_out  <= shift_rx;
         ser_last <= shift_tx;
      end
   end

   assign cs_cmd_n = !(shift_busy && shift_src == SRC_CMD);
   assign cs_ser_n = !(shift_busy && shift_src == SRC_SER);

endmodule

// File: rtl/ism_checker.sv
module ism_checker (
   input logic clk,
   input logic rst_n,
   input logic cs_cmd_n,
   input logic cs_ser_n,
   input logic sck,
   input logic frame_done,
   input logic tx_empty,
   input logic active
);
   p_cs_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!cs_cmd_n, !cs_ser_n}));

   p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_cmd_n && cs_ser_n) |-> !sck);

   p_ser_no_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_ser_n && !frame_done) |=> (!cs_ser_n && cs_cmd_n));

   p_cmd_no_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_cmd_n && !frame_done) |=> (!cs_cmd_n && cs_ser_n));

   p_cmd_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_cmd_n && cs_ser_n && !tx_empty && active) |=> !cs_cmd_n);

   p_ser_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_ser_n) |-> $past(tx_empty && active));

   p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_cmd_n && cs_ser_n && !active) |=> (cs_cmd_n && cs_ser_n));

endmodule

bind ism_link_master ism_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_cmd_n   (cs_cmd_n),
   .cs_ser_n   (cs_ser_n),
   .sck        (sck),
   .frame_done (shift_done),
   .tx_empty   (tx_empty),
   .active     (link_active)
);

// File: tb/tb_ism_link_master.sv
module tb_ism_link_master;
   localparam int CLK_P = 10;
   localparam int F     = 16;
   localparam int D     = 4;
   localparam logic [15:0] BASE = 16'h9D2B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_cfg = 2'b10;
   logic        master_en = 1'b1;
   logic [4:0]  cfg_size0 = 5'd7, cfg_size1 = 5'd8;
   logic [3:0]  cfg_div0 = 4'd0, cfg_div1 = 4'd0;
   logic        ser_attr_sel = 1'b0;
   logic        trig_en = 1'b1, trig_in = 1'b0;
   logic        tx_wr_en = 1'b0;
   logic [31:0] tx_wr_data = '0;
   logic        tx_full, rx_empty, sck, mosi, miso, cs_cmd_n, cs_ser_n;
   logic        rx_rd_en = 1'b0;
   logic [F-1:0] rx_rd_data, par_out, ser_last;
   logic [F-1:0] par_in = '0;

   int n_chk = 0, n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   ism_link_master dut (
      .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .master_en(master_en),
      .cfg_size0(cfg_size0), .cfg_div0(cfg_div0), .cfg_size1(cfg_size1), .cfg_div1(cfg_div1),
      .ser_attr_sel(ser_attr_sel), .trig_en(trig_en), .trig_in(trig_in),
      .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_full(tx_full),
      .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty),
      .par_in(par_in), .par_out(par_out), .ser_last(ser_last),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_cmd_n(cs_cmd_n), .cs_ser_n(cs_ser_n)
   );

   // slave model: reply word is BASE + index of the frame, sent MSB first
   logic        cs_any_n;
   logic [15:0] s_reply = '0;
   logic [15:0] s_in = '0;
   int          s_cnt = 0;
   int          nframes = 0;
   bit          cur_cmd = 1'b0, last_cmd = 1'b0;
   int          last_bits = 0;
   logic [15:0] last_in = '0;
   int          hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;

   assign cs_any_n = cs_cmd_n & cs_ser_n;
   assign miso     = s_reply[15];

   always @(negedge cs_any_n) begin
      s_reply = BASE + 16'(nframes);
      s_in    = '0;
      s_cnt   = 0;
      cur_cmd = !cs_cmd_n;
   end
   always @(posedge sck) begin
      s_in  = {s_in[14:0], mosi};
      s_cnt = s_cnt + 1;
   end
   always @(negedge sck) s_reply = s_reply << 1;
   always @(posedge cs_any_n) begin
      nframes   = nframes + 1;
      last_cmd  = cur_cmd;
      last_bits = s_cnt;
      last_in   = s_in;
   end
   always @(negedge clk) begin
      if (sck) begin
         hi_run = hi_run + 1;
         if (lo_run != 0) last_lo = lo_run;
         lo_run = 0;
      end else begin
         if (hi_run != 0) last_hi = hi_run;
         hi_run = 0;
         if (!cs_any_n) lo_run = lo_run + 1;
      end
   end

   function automatic int clampn(int s);
      return (s < 4) ? 4 : ((s > 16) ? 16 : s);
   endfunction
   function automatic logic [15:0] maskn(int n);
      return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
   endfunction
   function automatic logic [15:0] reply_of(int idx, int n);
      logic [15:0] r;
      r = BASE + 16'(idx);
      return r >> (16 - n);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic wait_frames(input int target);
      int t = 0;
      while (nframes < target && t < 5000) begin
         @(negedge clk);
         t++;
      end
      if (t >= 5000) check(1'b0, "R4", "frame timeout", 32'(nframes), 32'(target));
   endtask

   task automatic push_entry(input logic [31:0] e);
      @(negedge clk);
      tx_wr_en   = 1'b1;
      tx_wr_data = e;
      @(negedge clk);
      tx_wr_en   = 1'b0;
   endtask

   task automatic pop_rx(input logic [15:0] exp, input string req);
      check(!rx_empty, req, "rx queue has data", 32'(rx_empty), 32'd0);
      check(rx_rd_data == exp, req, "rx word", 32'(rx_rd_data), 32'(exp));
      rx_rd_en = 1'b1;
      @(negedge clk);
      rx_rd_en = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      check(1'b0, "R4", "watchdog expired", 32'(nframes), 32'd0);
      summary();
      $finish;
   end

   initial begin
      int n0, n, idx;
      logic [15:0] pv, dv16;
      repeat (3) @(negedge clk);
      // R5 R12 reset state
      check(cs_cmd_n && cs_ser_n, "R5", "selects idle in reset", {30'd0, cs_cmd_n, cs_ser_n}, 32'd3);
      check(!sck, "R5", "sck low in reset", 32'(sck), 32'd0);
      check(!tx_full && rx_empty, "R12", "queue flags in reset", {30'd0, tx_full, rx_empty}, 32'd1);
      check(par_out == 0 && ser_last == 0, "R7", "par_out cleared", 32'(par_out), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      nframes = 0;

      // R6 R8 R9 R7 command sweep over sizes and dividers
      for (int sz = 2; sz <= 18; sz++) begin
         for (int dvv = 0; dvv <= 2; dvv++) begin
            cfg_size1 = 5'(sz);
            cfg_div1  = 4'(dvv);
            n    = clampn(sz);
            dv16 = 16'hA5C3 ^ 16'(sz * 16'h1111) ^ 16'(dvv);
            n0   = nframes;
            push_entry({15'd0, 1'b1, dv16});
            wait_frames(n0 + 1);
            check(last_cmd, "R5", "command select used", 32'(last_cmd), 32'd1);
            check(last_bits == n, "R9", "clamped frame length", 32'(last_bits), 32'(n));
            check(last_in == (dv16 & maskn(n)), "R6", "mosi bits msb first", 32'(last_in), 32'(dv16 & maskn(n)));
            check(last_hi == dvv + 1, "R8", "sck high half", 32'(last_hi), 32'(dvv + 1));
            check(last_lo == dvv + 1, "R8", "sck low half", 32'(last_lo), 32'(dvv + 1));
            pop_rx(reply_of(n0, n), "R7");
         end
      end

      // R9 bit 16 clear selects set 0 (size 7)
      cfg_size0 = 5'd7; cfg_div0 = 4'd1;
      n0 = nframes;
      push_entry({15'h7FFF, 1'b0, 16'h5A5A});
      wait_frames(n0 + 1);
      check(last_bits == 7, "R9", "entry selects set 0", 32'(last_bits), 32'd7);
      check(last_in == 16'h005A, "R6", "upper entry bits ignored", 32'(last_in), 32'h5A);
      pop_rx(reply_of(n0, 7), "R7");

      // R1 R4 R7 R9 R11 triggered serializer frames
      for (int sel = 0; sel < 2; sel++) begin
         for (int k = 0; k < 3; k++) begin
            n = (k == 0) ? 4 : ((k == 1) ? 9 : 16);
            ser_attr_sel = sel[0];
            if (sel == 0) begin cfg_size0 = 5'(n); cfg_div0 = 4'(k); end
            else          begin cfg_size1 = 5'(n); cfg_div1 = 4'(k); end
            pv = 16'h3C96 ^ 16'(k * 16'h0F0F) ^ 16'(sel * 16'h8421);
            par_in = pv;
            repeat (2) @(negedge clk);
            trig_in = 1'b1;
            idx = 0;
            while (cs_ser_n && idx < 1000) begin @(negedge clk); idx++; end
            trig_in = 1'b0;
            n0 = nframes;
            par_in = ~pv;
            wait_frames(n0 + 1);
            check(!last_cmd, "R5", "serializer select used", 32'(last_cmd), 32'd0);
            check(last_bits == n, "R9", "serializer attribute set", 32'(last_bits), 32'(n));
            check(last_in == (pv & maskn(n)), "R1", "sampled word sent", 32'(last_in), 32'(pv & maskn(n)));
            check(par_out == reply_of(n0, n), "R7", "par_out from returned bits", 32'(par_out), 32'(reply_of(n0, n)));
            check(ser_last == (pv & maskn(n)), "R11", "last serializer word", 32'(ser_last), 32'(pv & maskn(n)));
            check(rx_empty, "R7", "serializer bits not queued", 32'(rx_empty), 32'd1);
         end
      end

      // R4 no trigger, no serializer frame
      n0 = nframes;
      repeat (100) @(negedge clk);
      check(nframes == n0, "R4", "trigger low holds link", 32'(nframes), 32'(n0));

      // R2 R3 R4 continuous frames with a command arriving mid-frame
      ser_attr_sel = 1'b0; cfg_size0 = 5'd8; cfg_div0 = 4'd1;
      cfg_size1 = 5'd12; cfg_div1 = 4'd0;
      par_in = 16'h00C5;
      trig_en = 1'b0;
      n0 = nframes;
      wait_frames(n0 + 2);
      check(!last_cmd && last_bits == 8, "R4", "continuous serializer frames", 32'(last_bits), 32'd8);
      idx = 0;
      while (cs_ser_n && idx < 1000) begin @(negedge clk); idx++; end
      n0 = nframes;
      push_entry({15'd0, 1'b1, 16'h0ABC});
      wait_frames(n0 + 1);
      check(!last_cmd && last_bits == 8, "R3", "active frame completes", 32'(last_bits), 32'd8);
      wait_frames(n0 + 2);
      check(last_cmd, "R2", "command wins next boundary", 32'(last_cmd), 32'd1);
      check(last_in == 16'h0ABC, "R2", "command data", 32'(last_in), 32'h0ABC);
      wait_frames(n0 + 3);
      check(!last_cmd, "R4", "serializer resumes", 32'(last_cmd), 32'd0);
      trig_en = 1'b1;
      repeat (200) @(negedge clk);
      pop_rx(reply_of(n0 + 1, 12), "R7");

      // R10 enable gating
      n0 = nframes;
      mode_cfg = 2'b01;
      push_entry({15'd0, 1'b1, 16'h0123});
      repeat (100) @(negedge clk);
      check(nframes == n0 && cs_cmd_n, "R10", "wrong mode holds entry", 32'(nframes), 32'(n0));
      mode_cfg = 2'b10; master_en = 1'b0;
      repeat (100) @(negedge clk);
      check(nframes == n0 && cs_cmd_n, "R10", "master off holds entry", 32'(nframes), 32'(n0));
      master_en = 1'b1;
      wait_frames(n0 + 1);
      check(last_cmd && last_in == 16'h0123, "R10", "entry sent once enabled", 32'(last_in), 32'h0123);
      pop_rx(reply_of(n0, 12), "R7");

      // R12 full transmit queue, R7 full receive queue
      cfg_size1 = 5'd16; cfg_div1 = 4'd0;
      mode_cfg = 2'b00;
      n0 = nframes;
      for (int k = 0; k <= D; k++) push_entry({15'd0, 1'b1, 16'h1000 + 16'(k)});
      check(tx_full, "R12", "tx_full after depth writes", 32'(tx_full), 32'd1);
      mode_cfg = 2'b10;
      wait_frames(n0 + D);
      repeat (60) @(negedge clk);
      check(nframes == n0 + D, "R12", "write while full ignored", 32'(nframes), 32'(n0 + D));
      check(last_in == 16'h1000 + 16'(D - 1), "R12", "last kept entry", 32'(last_in), 32'(16'h1000 + D - 1));
      push_entry({15'd0, 1'b1, 16'h2000});
      wait_frames(n0 + D + 1);
      for (int k = 0; k < D; k++) pop_rx(BASE + 16'(n0 + k), "R7");
      check(rx_empty, "R7", "push into full rx dropped", 32'(rx_empty), 32'd1);

      summary();
      $finish;
   end
endmodule